// File: doc/BRIEF.md
# Cartridge Bank Mapper with RAM Overlay

This block sits between an 8-bit processor with a 16-bit address bus and a cartridge that holds a banked ROM and a battery-backed RAM. It watches processor writes to the top four bytes of the address space and keeps four paging registers there. The first one is a control register. The other three select which 16 KB ROM page appears in each of the three lower 16 KB windows of the address space.

For every processor address, the block works out combinationally from its registered state which memory is targeted: cartridge ROM, cartridge RAM or the console's internal work RAM. It also gives the physical address inside that memory and a write enable for whichever RAM is addressed. The control register can switch the third window, the top window, or both, over to cartridge RAM. Its low two bits add a fixed offset to every ROM page index. The first kilobyte of the address space always reads ROM page 0, so the boot code stays in place.

A sticky status flag tells the save logic that cartridge RAM has been switched in at least once since reset.

Top module: `cart_bank_mapper`

## Requirements
- R1: A processor write to FFFC, FFFD, FFFE or FFFF loads control register 0 or bank register 1, 2 or 3 respectively, and the new value governs translation from the next cycle on. The same write also reaches the RAM that backs that address, with its write enable asserted.
- R2: Window 0000-3FFF reads ROM at the page in register 1, 4000-7FFF at the page in register 2 and 8000-BFFF at the page in register 3. The ROM address is {page, cpuAddr[13:0]}. Target encoding: 0 = cartridge ROM, 1 = cartridge RAM, 2 = internal RAM.
- R3: A page index is the register value modulo the ROM page count. A page count input of zero is treated as one.
- R4: When control bits [1:0] hold a nonzero shift s, every bank page becomes (register mod count + (4 - s) * 8) mod count.
- R5: With control bit 3 set, 8000-BFFF targets cartridge RAM read/write at address {bit 2, cpuAddr[13:0]}, and register 3 has no effect on that window while bit 3 stays set.
- R6: With control bit 4 set, C000-FFFF targets cartridge RAM at {0, cpuAddr[13:0]}. Otherwise C000-FFFF targets internal RAM at cpuAddr[12:0], an 8 KB mirror.
- R7: Addresses 0000-03FF always read ROM page 0 at the raw address, whatever registers 0 and 1 hold.
- R8: Reset loads the registers with 0, 0, 1, 2 (control, then banks 1 to 3) and clears the status flag.
- R9: A processor write that lands in a ROM window asserts neither RAM write enable.
- R10: The status flag rises on the cycle after a control write that has bit 3 or bit 4 set. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | Processor address |
| cpuWrData | input | 8 | Processor write data |
| cpuWrEn | input | 1 | Processor write strobe |
| romPages | input | PAGE_BITS+1 | Number of 16 KB ROM pages present |
| target | output | 2 | Decoded target: 0 ROM, 1 cartridge RAM, 2 internal RAM |
| romAddr | output | PAGE_BITS+14 | Physical ROM byte address |
| cartRamAddr | output | 15 | Cartridge RAM byte address |
| wramAddr | output | 13 | Internal RAM byte address |
| cartRamWe | output | 1 | Write enable for cartridge RAM |
| wramWe | output | 1 | Write enable for internal RAM |
| cartRamSeen | output | 1 | Sticky flag: cartridge RAM has been mapped in |

## Verification
Translation is combinational from the registers, so a wrong register value shows up at romAddr or target on the very first probe of the affected window after the write. No further cycles are needed to expose it. A shift or modulo fault changes the ROM page number in the upper address bits, and a wrong overlay bit flips target. A write-decode fault shows up as a stray or missing write enable in the same cycle as the write. The bench probes each window after every register change and checks the write enables during writes to ROM windows, to register addresses and to overlay windows.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  typedef enum logic [1:0] {
    TGT_ROM  = 2'd0,
    TGT_CART = 2'd1,
    TGT_WRAM = 2'd2
  } tgt_e;

  // Load strobes from the write decoder to the register datapath
  typedef struct packed {
    logic [3:0] load;
    logic [7:0] data;
  } regStrobe_t;

endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import cart_map_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  input  logic        cpuWrEn,
  output regStrobe_t  strobe
);

  localparam int NUM_REGS = 4;
  localparam logic [13:0] REG_PAGE = 14'h3FFF;

  logic hitTop;
  assign hitTop = cpuWrEn && (cpuAddr[15:2] == REG_PAGE);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_load
    assign strobe.load[i] = hitTop && (cpuAddr[1:0] == 2'(i));
  end
  assign strobe.data = cpuWrData;

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.load)); // R1
  AST_LOAD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load != 4'b0) |-> (cpuWrEn && cpuAddr >= 16'hFFFC)); // R1

endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import cart_map_pkg::*;
#(
  parameter int PAGE_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strobe,
  input  logic [15:0]            cpuAddr,
  input  logic                   cpuWrEn,
  input  logic [PAGE_BITS:0]     romPages,
  output logic [1:0]             target,
  output logic [PAGE_BITS+13:0]  romAddr,
  output logic [14:0]            cartRamAddr,
  output logic [12:0]            wramAddr,
  output logic                   cartRamWe,
  output logic                   wramWe,
  output logic                   cartRamSeen
);

  localparam int ROM_BITS = PAGE_BITS + 14;
  localparam int SW = ((PAGE_BITS > 8) ? PAGE_BITS : 8) + 2;
  localparam int NUM_WIN = 3;

  logic [4:0] ctrlReg;
  logic [7:0] bankReg [NUM_WIN];
  logic [PAGE_BITS-1:0] winPage [NUM_WIN];
  logic [PAGE_BITS:0] effPages;

  assign effPages = (romPages == '0) ? (PAGE_BITS+1)'(1) : romPages;

  function automatic logic [PAGE_BITS-1:0] mapPage(
    input logic [7:0] raw, input logic [1:0] shift, input logic [PAGE_BITS:0] cnt);
    logic [SW-1:0] p;
    p = SW'(raw) % SW'(cnt);
    if (shift != 2'd0)
      p = (p + SW'({3'd4 - {1'b0, shift}, 3'b000})) % SW'(cnt);
    return PAGE_BITS'(p);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg     <= 5'd0;
      cartRamSeen <= 1'b0;
    end else if (strobe.load[0]) begin
      ctrlReg <= strobe.data[4:0];
      if (strobe.data[3] || strobe.data[4]) cartRamSeen <= 1'b1;
    end
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rstN) bankReg[w] <= 8'(w);
      else if (strobe.load[w+1]) bankReg[w] <= strobe.data;
    end
    assign winPage[w] = mapPage(bankReg[w], ctrlReg[1:0], effPages);
  end

  always_comb begin
    target      = TGT_ROM;
    romAddr     = '0;
    cartRamAddr = '0;
    wramAddr    = '0;
    unique case (cpuAddr[15:14])
      2'd0: begin
        if (cpuAddr[13:10] == 4'd0) romAddr = ROM_BITS'(cpuAddr[13:0]);
        else romAddr = {winPage[0], cpuAddr[13:0]};
      end
      2'd1: romAddr = {winPage[1], cpuAddr[13:0]};
      2'd2: begin
        if (ctrlReg[3]) begin
          target      = TGT_CART;
          cartRamAddr = {ctrlReg[2], cpuAddr[13:0]};
        end else begin
          romAddr = {winPage[2], cpuAddr[13:0]};
        end
      end
      default: begin
        if (ctrlReg[4]) begin
          target      = TGT_CART;
          cartRamAddr = {1'b0, cpuAddr[13:0]};
        end else begin
          target   = TGT_WRAM;
          wramAddr = cpuAddr[12:0];
        end
      end
    endcase
  end

  assign cartRamWe = cpuWrEn && (target == TGT_CART);
  assign wramWe    = cpuWrEn && (target == TGT_WRAM);

  AST_ROM_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && cpuAddr[15] == 1'b0) |-> (!cartRamWe && !wramWe)); // R9
  AST_FIXED_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr < 16'h0400) |-> (romAddr == ROM_BITS'(cpuAddr) && target == TGT_ROM)); // R7
  AST_OVERLAY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[3] && cpuAddr[15:14] == 2'd2) |-> (target == TGT_CART)); // R5
  AST_PAGE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (target == TGT_ROM) |-> ((PAGE_BITS+1)'(romAddr[ROM_BITS-1:14]) < effPages)); // R3
  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cartRamSeen |=> cartRamSeen); // R10
  AST_ONE_WE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cartRamWe, wramWe})); // R6

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter int PAGE_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [15:0]           cpuAddr,
  input  logic [7:0]            cpuWrData,
  input  logic                  cpuWrEn,
  input  logic [PAGE_BITS:0]    romPages,
  output logic [1:0]            target,
  output logic [PAGE_BITS+13:0] romAddr,
  output logic [14:0]           cartRamAddr,
  output logic [12:0]           wramAddr,
  output logic                  cartRamWe,
  output logic                  wramWe,
  output logic                  cartRamSeen
);

  regStrobe_t strobe;

  mapper_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .cpuWrEn   (cpuWrEn),
    .strobe    (strobe)
  );

  bank_datapath #(.PAGE_BITS(PAGE_BITS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cpuAddr     (cpuAddr),
    .cpuWrEn     (cpuWrEn),
    .romPages    (romPages),
    .target      (target),
    .romAddr     (romAddr),
    .cartRamAddr (cartRamAddr),
    .wramAddr    (wramAddr),
    .cartRamWe   (cartRamWe),
    .wramWe      (wramWe),
    .cartRamSeen (cartRamSeen)
  );

endmodule

// File: tb/sim_cart_bank_mapper.sv
module sim_cart_bank_mapper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = 16'h0;
  logic [7:0]  cpuWrData = 8'h0;
  logic        cpuWrEn = 1'b0;
  logic [8:0]  romPages = 9'd20;
  logic [1:0]  target;
  logic [21:0] romAddr;
  logic [14:0] cartRamAddr;
  logic [12:0] wramAddr;
  logic        cartRamWe, wramWe, cartRamSeen;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cart_bank_mapper u0 (.*);

  typedef struct packed {
    logic        we;
    logic [15:0] wa;
    logic [7:0]  wd;
    logic [15:0] pa;
    logic [1:0]  tg;
    logic [21:0] ph;
  } vec_t;

  localparam int NV = 18;
  // romPages = 20; targets 0 ROM, 1 cart RAM, 2 internal RAM
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0000, 8'h00, 16'h0500, 2'd0, 22'h000500}, // R2 R8 reg1=0
    '{1'b0, 16'h0000, 8'h00, 16'h4123, 2'd0, 22'h004123}, // R2 R8 reg2=1
    '{1'b0, 16'h0000, 8'h00, 16'h8010, 2'd0, 22'h008010}, // R2 R8 reg3=2
    '{1'b0, 16'h0000, 8'h00, 16'hC005, 2'd2, 22'h000005}, // R6 internal RAM
    '{1'b0, 16'h0000, 8'h00, 16'hE005, 2'd2, 22'h000005}, // R6 mirror
    '{1'b1, 16'hFFFE, 8'd5,  16'h4001, 2'd0, 22'h014001}, // R1 R2
    '{1'b1, 16'hFFFD, 8'd23, 16'h0400, 2'd0, 22'h00C400}, // R3 23 mod 20
    '{1'b1, 16'hFFFD, 8'd7,  16'h0000, 2'd0, 22'h000000}, // R7
    '{1'b1, 16'hFFFF, 8'd41, 16'hBFFF, 2'd0, 22'h007FFF}, // R3 41 mod 20
    '{1'b1, 16'hFFFC, 8'h01, 16'h4000, 2'd0, 22'h024000}, // R4 (5+24)%20
    '{1'b0, 16'h0000, 8'h00, 16'h0000, 2'd0, 22'h000000}, // R7 under shift
    '{1'b1, 16'hFFFC, 8'h03, 16'h8000, 2'd0, 22'h024000}, // R4 (1+8)%20
    '{1'b1, 16'hFFFC, 8'h08, 16'h8123, 2'd1, 22'h000123}, // R5 lower half
    '{1'b1, 16'hFFFF, 8'd3,  16'h9000, 2'd1, 22'h001000}, // R5 reg3 ignored
    '{1'b1, 16'hFFFC, 8'h0C, 16'hA000, 2'd1, 22'h006000}, // R5 upper half
    '{1'b1, 16'hFFFC, 8'h10, 16'h8004, 2'd0, 22'h00C004}, // R5 reg3 applies again
    '{1'b0, 16'h0000, 8'h00, 16'hD234, 2'd1, 22'h001234}, // R6 top overlay
    '{1'b1, 16'hFFFC, 8'h00, 16'hD234, 2'd2, 22'h001234}  // R6 back to internal
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] phys();
    case (target)
      2'd0:    return romAddr;
      2'd1:    return 22'(cartRamAddr);
      default: return 22'(wramAddr);
    endcase
  endfunction

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddr = a; cpuWrData = d;
  endtask

  task automatic probe(input logic [15:0] a);
    @(negedge clk);
    cpuWrEn = 1'b0; cpuAddr = a;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    cpuWrEn = 1'b0; rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    probe(16'h0100);
    check("R8 seen after reset", 32'(cartRamSeen), 0);
    probe(16'h8000);
    check("R8 reg3 reset page", 32'(romAddr), 32'h8000);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) doWrite(VECS[i].wa, VECS[i].wd);
      probe(VECS[i].pa);
      check($sformatf("vector %0d target", i), 32'(target), 32'(VECS[i].tg));
      check($sformatf("vector %0d addr", i), 32'(phys()), 32'(VECS[i].ph));
    end
    check("R10 seen after overlay", 32'(cartRamSeen), 1);

    // R1: register write also reaches backing internal RAM
    doWrite(16'hFFFD, 8'd2);
    #1;
    check("R1 wramWe on reg write", 32'(wramWe), 1);
    check("R1 wramAddr on reg write", 32'(wramAddr), 32'h1FFD);
    probe(16'h0400);
    check("R1 reg1 loaded", 32'(romAddr), 32'h8400);

    // R9: write into ROM window discarded
    doWrite(16'h2000, 8'hAA);
    #1;
    check("R9 no write enable", 32'({cartRamWe, wramWe}), 0);
    probe(16'h0400);
    check("R9 mapping unchanged", 32'(romAddr), 32'h8400);

    // R5: write into cart RAM window
    doWrite(16'hFFFC, 8'h08);
    doWrite(16'h8004, 8'h55);
    #1;
    check("R5 cartRamWe", 32'(cartRamWe), 1);
    check("R5 cartRamAddr", 32'(cartRamAddr), 32'h0004);

    // R8 R10: reset clears flag and registers
    doReset();
    probe(16'h0400);
    check("R8 seen cleared", 32'(cartRamSeen), 0);
    check("R8 reg1 reset", 32'(romAddr), 32'h0400);
    doWrite(16'hFFFC, 8'h10);
    probe(16'h0000);
    check("R10 seen rises", 32'(cartRamSeen), 1);
    doWrite(16'hFFFC, 8'h00);
    probe(16'h0000);
    check("R10 seen sticky", 32'(cartRamSeen), 1);

    // R3: page count zero treated as one
    romPages = 9'd0;
    probe(16'h4000);
    check("R3 zero count", 32'(romAddr), 32'h0000);
    romPages = 9'd20;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule